// File: doc/BRIEF.md
# Bypass-Capable Three-Port Packet Switching Element

This block is a single switching element for a multistage self-routing packet fabric. It has three packet inputs. Inputs 0 and 1 arrive over the shuffle wiring from the previous stage. Input 2 is the horizontal link from the element in the same row of the previous stage. It has three outputs: upper shuffle (port 0), lower shuffle (port 1) and horizontal (port 2). Each packet carries a destination address and a hop count. The hop count records how many correct routing steps the packet has taken in a row. In one cycle the element decides, for every packet, whether it is routed, bypassed along the horizontal link, deflected or discarded. The decisions are registered, so every output appears one clock after its input.

The data interface is valid-only. The fabric has no back-pressure. There is no ready signal, the outputs are always taken, and the element holds no packet beyond its single output register. A packet that cannot be placed is dropped, and a one-cycle pulse flags the input it came on.

Top module: `sw3_bypass_elem`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every output valid bit and every drop pulse is 0.
- R2: A valid packet with hop count h below ADDR_W requests output port 0 when bit h of its destination is 0 and port 1 when that bit is 1 (bit 0 is consulted first). When it gets that port, it leaves one cycle later with hop count h+1.
- R3: A valid packet with hop count at least ADDR_W has arrived at its row. It may only use port 2, and if it gets that port it leaves with its hop count unchanged.
- R4: Port 2 is given to arrived packets in the fixed order input 2, then input 0, then input 1.
- R5: An arrived packet that loses port 2 is discarded. It is not deflected, even if a shuffle port is free, and drop_pulse bit i (for input i) is high for exactly one cycle.
- R6: When two or more routing packets request the same shuffle port, the one with the higher hop count wins. On equal hop counts the lower input index wins.
- R7: A losing routing packet is deflected to the other shuffle port if that port is free, with its hop count set to 0.
- R8: If both shuffle ports are taken, a losing routing packet is deflected to port 2 when no arrived packet holds it, with hop count 0. Otherwise it is discarded.
- R9: Invalid inputs produce no output and no drop pulse, whatever their destination and hop fields hold.
- R10: Every valid input appears exactly once one cycle later, either on one output or as one drop pulse.
- R11: The destination field leaves unchanged with its packet on whichever port the packet takes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_in_vld | input | 3 | Valid bit per input (bit i = input i) |
| pkt_in_dst | input | 3*ADDR_W | Destination per input, input i at bits [i*ADDR_W +: ADDR_W] |
| pkt_in_hop | input | 3*HOP_W | Hop count per input, input i at bits [i*HOP_W +: HOP_W] |
| pkt_out_vld | output | 3 | Valid bit per output port (0 upper, 1 lower, 2 horizontal) |
| pkt_out_dst | output | 3*ADDR_W | Destination per output port, same packing |
| pkt_out_hop | output | 3*HOP_W | Hop count per output port, same packing |
| drop_pulse | output | 3 | One-cycle discard flag per input index |

## Verification
The assertions check four rules on every cycle. Packets are conserved between inputs and the outputs plus drops. Drops only come from valid inputs. Any packet leaving a shuffle port with nonzero hop count took the direction its destination bit asked for. Whenever an arrived packet was present, the horizontal port carries a packet with full hop count. Only the directed scenarios can show the arbitration outcomes: which contender wins on hop count or on index, where the loser is deflected, and that its count is cleared. The same holds for the horizontal priority order and for which input's drop bit fires.

// File: rtl/sw3_pkg.sv
`timescale 1ns/1ps
package sw3_pkg;
  localparam int NPORT   = 3;
  localparam int PORT_UP = 0;
  localparam int PORT_DN = 1;
  localparam int PORT_HZ = 2;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_ROUTE,
    OP_DEFLECT,
    OP_BYPASS,
    OP_DROP
  } sw_op_e;
endpackage

// File: rtl/sw3_tag_decode.sv
`timescale 1ns/1ps
module sw3_tag_decode #(
  parameter int ADDR_W = 3,
  parameter int HOP_W  = 2
) (
  input  logic              vld,
  input  logic [ADDR_W-1:0] dst,
  input  logic [HOP_W-1:0]  hop,
  output logic              arrived,
  output logic              routing,
  output logic              want_dn
);
  // Packet has finished its routing steps once hop reaches ADDR_W
  always_comb begin
    arrived = vld && (hop >= HOP_W'(ADDR_W));
    routing = vld && (hop <  HOP_W'(ADDR_W));
    want_dn = 1'b0;
    for (int k = 0; k < ADDR_W; k++) begin
      if (hop == HOP_W'(k)) want_dn = dst[k];
    end
  end
endmodule

// File: rtl/sw3_alloc.sv
`timescale 1ns/1ps
module sw3_alloc
  import sw3_pkg::*;
#(
  parameter int HOP_W = 2
) (
  input  logic              arrived [NPORT],
  input  logic              routing [NPORT],
  input  logic              want_dn [NPORT],
  input  logic [HOP_W-1:0]  hop     [NPORT],
  output sw_op_e            op      [NPORT],
  output logic [1:0]        port    [NPORT]
);
  localparam int HZ_ORDER [NPORT] = '{2, 0, 1};

  logic [1:0] rank    [NPORT];
  logic       busy    [NPORT];
  logic       granted [NPORT];

  // Rank: number of inputs that beat input i (higher hop, or equal hop and lower index)
  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      rank[i] = 2'd0;
      for (int j = 0; j < NPORT; j++) begin
        if (j != i && ((hop[j] > hop[i]) || (hop[j] == hop[i] && j < i)))
          rank[i] = rank[i] + 2'd1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      op[i]      = OP_IDLE;
      port[i]    = 2'd0;
      busy[i]    = 1'b0;
      granted[i] = 1'b0;
    end

    // Horizontal port: arrived packets in fixed priority order
    for (int k = 0; k < NPORT; k++) begin
      if (arrived[HZ_ORDER[k]]) begin
        if (!busy[PORT_HZ]) begin
          busy[PORT_HZ]        = 1'b1;
          op[HZ_ORDER[k]]      = OP_BYPASS;
          port[HZ_ORDER[k]]    = 2'(PORT_HZ);
        end else begin
          op[HZ_ORDER[k]]      = OP_DROP;
        end
      end
    end

    // Requested shuffle ports, best-ranked requester first
    for (int r = 0; r < NPORT; r++) begin
      for (int i = 0; i < NPORT; i++) begin
        if (routing[i] && rank[i] == 2'(r)) begin
          if (!busy[want_dn[i] ? PORT_DN : PORT_UP]) begin
            busy[want_dn[i] ? PORT_DN : PORT_UP] = 1'b1;
            op[i]      = OP_ROUTE;
            port[i]    = want_dn[i] ? 2'(PORT_DN) : 2'(PORT_UP);
            granted[i] = 1'b1;
          end
        end
      end
    end

    // Losers take leftovers: other shuffle port, then horizontal, else drop
    for (int r = 0; r < NPORT; r++) begin
      for (int i = 0; i < NPORT; i++) begin
        if (routing[i] && !granted[i] && rank[i] == 2'(r)) begin
          if (!busy[want_dn[i] ? PORT_UP : PORT_DN]) begin
            busy[want_dn[i] ? PORT_UP : PORT_DN] = 1'b1;
            op[i]   = OP_DEFLECT;
            port[i] = want_dn[i] ? 2'(PORT_UP) : 2'(PORT_DN);
          end else if (!busy[PORT_HZ]) begin
            busy[PORT_HZ] = 1'b1;
            op[i]   = OP_DEFLECT;
            port[i] = 2'(PORT_HZ);
          end else begin
            op[i]   = OP_DROP;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sw3_out_stage.sv
`timescale 1ns/1ps
module sw3_out_stage
  import sw3_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int HOP_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sw_op_e            op   [NPORT],
  input  logic [1:0]        port [NPORT],
  input  logic [ADDR_W-1:0] dst  [NPORT],
  input  logic [HOP_W-1:0]  hop  [NPORT],
  output logic [NPORT-1:0]  q_vld,
  output logic [ADDR_W-1:0] q_dst [NPORT],
  output logic [HOP_W-1:0]  q_hop [NPORT],
  output logic [NPORT-1:0]  q_drop
);
  logic [NPORT-1:0]  d_vld;
  logic [ADDR_W-1:0] d_dst [NPORT];
  logic [HOP_W-1:0]  d_hop [NPORT];
  logic [NPORT-1:0]  d_drop;

  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      d_vld[o] = 1'b0;
      d_dst[o] = '0;
      d_hop[o] = '0;
      for (int i = 0; i < NPORT; i++) begin
        if ((op[i] == OP_ROUTE || op[i] == OP_DEFLECT || op[i] == OP_BYPASS)
            && port[i] == 2'(o)) begin
          d_vld[o] = 1'b1;
          d_dst[o] = dst[i];
          unique case (op[i])
            OP_ROUTE:  d_hop[o] = hop[i] + HOP_W'(1);
            OP_BYPASS: d_hop[o] = hop[i];
            default:   d_hop[o] = '0;
          endcase
        end
      end
    end
    for (int i = 0; i < NPORT; i++) d_drop[i] = (op[i] == OP_DROP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld  <= '0;
      q_drop <= '0;
      for (int o = 0; o < NPORT; o++) begin
        q_dst[o] <= '0;
        q_hop[o] <= '0;
      end
    end else begin
      q_vld  <= d_vld;
      q_drop <= d_drop;
      for (int o = 0; o < NPORT; o++) begin
        q_dst[o] <= d_dst[o];
        q_hop[o] <= d_hop[o];
      end
    end
  end
endmodule

// File: rtl/sw3_bypass_elem.sv
`timescale 1ns/1ps
module sw3_bypass_elem
  import sw3_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int HOP_W = $clog2(ADDR_W + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT-1:0]        pkt_in_vld,
  input  logic [NPORT*ADDR_W-1:0] pkt_in_dst,
  input  logic [NPORT*HOP_W-1:0]  pkt_in_hop,
  output logic [NPORT-1:0]        pkt_out_vld,
  output logic [NPORT*ADDR_W-1:0] pkt_out_dst,
  output logic [NPORT*HOP_W-1:0]  pkt_out_hop,
  output logic [NPORT-1:0]        drop_pulse
);
  logic [ADDR_W-1:0] in_dst  [NPORT];
  logic [HOP_W-1:0]  in_hop  [NPORT];
  logic              arrived [NPORT];
  logic              routing [NPORT];
  logic              want_dn [NPORT];
  sw_op_e            op      [NPORT];
  logic [1:0]        port    [NPORT];
  logic [ADDR_W-1:0] q_dst   [NPORT];
  logic [HOP_W-1:0]  q_hop   [NPORT];

  for (genvar g = 0; g < NPORT; g++) begin : g_in
    assign in_dst[g] = pkt_in_dst[g*ADDR_W +: ADDR_W];
    assign in_hop[g] = pkt_in_hop[g*HOP_W +: HOP_W];

    sw3_tag_decode #(.ADDR_W(ADDR_W), .HOP_W(HOP_W)) u_dec (
      .vld     (pkt_in_vld[g]),
      .dst     (in_dst[g]),
      .hop     (in_hop[g]),
      .arrived (arrived[g]),
      .routing (routing[g]),
      .want_dn (want_dn[g])
    );

    assign pkt_out_dst[g*ADDR_W +: ADDR_W] = q_dst[g];
    assign pkt_out_hop[g*HOP_W +: HOP_W]   = q_hop[g];
  end

  sw3_alloc #(.HOP_W(HOP_W)) u_alloc (
    .arrived (arrived),
    .routing (routing),
    .want_dn (want_dn),
    .hop     (in_hop),
    .op      (op),
    .port    (port)
  );

  sw3_out_stage #(.ADDR_W(ADDR_W), .HOP_W(HOP_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .port   (port),
    .dst    (in_dst),
    .hop    (in_hop),
    .q_vld  (pkt_out_vld),
    .q_dst  (q_dst),
    .q_hop  (q_hop),
    .q_drop (drop_pulse)
  );
endmodule

// File: rtl/sw3_bypass_chk.sv
`timescale 1ns/1ps
module sw3_bypass_chk #(
  parameter int ADDR_W = 3,
  parameter int HOP_W  = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [2:0]            pkt_in_vld,
  input logic [3*HOP_W-1:0]    pkt_in_hop,
  input logic [2:0]            pkt_out_vld,
  input logic [3*ADDR_W-1:0]   pkt_out_dst,
  input logic [3*HOP_W-1:0]    pkt_out_hop,
  input logic [2:0]            drop_pulse
);
  logic armed;
  logic any_arrived;
  logic up_dir_ok, dn_dir_ok;
  logic [HOP_W-1:0]  hop0, hop1, hop2;
  logic [ADDR_W-1:0] dst0, dst1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign hop0 = pkt_out_hop[0 +: HOP_W];
  assign hop1 = pkt_out_hop[HOP_W +: HOP_W];
  assign hop2 = pkt_out_hop[2*HOP_W +: HOP_W];
  assign dst0 = pkt_out_dst[0 +: ADDR_W];
  assign dst1 = pkt_out_dst[ADDR_W +: ADDR_W];

  always_comb begin
    any_arrived = 1'b0;
    for (int i = 0; i < 3; i++)
      if (pkt_in_vld[i] && pkt_in_hop[i*HOP_W +: HOP_W] >= HOP_W'(ADDR_W))
        any_arrived = 1'b1;
    up_dir_ok = 1'b1;
    dn_dir_ok = 1'b1;
    for (int k = 1; k <= ADDR_W; k++) begin
      if (hop0 == HOP_W'(k) && dst0[k-1]) up_dir_ok = 1'b0;
      if (hop1 == HOP_W'(k) && !dst1[k-1]) dn_dir_ok = 1'b0;
    end
  end

  // R10
  conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ($countones(pkt_out_vld) + $countones(drop_pulse)
               == $past($countones(pkt_in_vld))));

  // R9
  drop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((drop_pulse & ~$past(pkt_in_vld)) == 3'b000));

  // R2
  up_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_out_vld[0] |-> up_dir_ok);

  // R2
  dn_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_out_vld[1] |-> dn_dir_ok);

  // R3
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(any_arrived)) |-> (pkt_out_vld[2] && hop2 >= HOP_W'(ADDR_W)));
endmodule

bind sw3_bypass_elem sw3_bypass_chk #(.ADDR_W(ADDR_W), .HOP_W(HOP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pkt_in_vld  (pkt_in_vld),
  .pkt_in_hop  (pkt_in_hop),
  .pkt_out_vld (pkt_out_vld),
  .pkt_out_dst (pkt_out_dst),
  .pkt_out_hop (pkt_out_hop),
  .drop_pulse  (drop_pulse)
);

// File: tb/sim_sw3_bypass_elem.sv
`timescale 1ns/1ps
module sim_sw3_bypass_elem;
  localparam int AW = 3;
  localparam int HW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    pkt_in_vld = '0;
  logic [3*AW-1:0] pkt_in_dst = '0;
  logic [3*HW-1:0] pkt_in_hop = '0;
  logic [2:0]    pkt_out_vld;
  logic [3*AW-1:0] pkt_out_dst;
  logic [3*HW-1:0] pkt_out_hop;
  logic [2:0]    drop_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sw3_bypass_elem #(.ADDR_W(AW)) u0 (.*);

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_port(string tag, int o, int v, int d, int h);
    chk(tag, $sformatf("port%0d valid", o), int'(pkt_out_vld[o]), v);
    if (v != 0) begin
      chk(tag, $sformatf("port%0d dest", o), int'(pkt_out_dst[o*AW +: AW]), d);
      chk(tag, $sformatf("port%0d hop", o), int'(pkt_out_hop[o*HW +: HW]), h);
    end
  endtask

  task automatic set_in(int i, bit v, int d, int h);
    pkt_in_vld[i]          = v;
    pkt_in_dst[i*AW +: AW] = AW'(d);
    pkt_in_hop[i*HW +: HW] = HW'(h);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    pkt_in_vld = '0;
  endtask

  task automatic t_reset();
    chk("R1", "valid in reset", int'(pkt_out_vld), 0);
    chk("R1", "drop in reset", int'(drop_pulse), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1", "valid after reset", int'(pkt_out_vld), 0);
    chk("R1", "drop after reset", int'(drop_pulse), 0);
  endtask

  task automatic t_route();
    set_in(0, 1, 3'b101, 0);   // bit0=1 -> lower
    set_in(1, 1, 3'b010, 2);   // bit2=0 -> upper
    step();
    chk_port("R2", 1, 1, 3'b101, 1);
    chk_port("R11", 0, 1, 3'b010, 3);
    chk_port("R2", 2, 0, 0, 0);
    chk("R10", "drop", int'(drop_pulse), 0);
  endtask

  task automatic t_arrive();
    set_in(1, 1, 6, 3);
    step();
    chk_port("R3", 2, 1, 6, 3);
    chk("R3", "shuffle valid", int'(pkt_out_vld[1:0]), 0);
  endtask

  task automatic t_hz_prio();
    set_in(0, 1, 2, 3); set_in(1, 1, 3, 3); set_in(2, 1, 1, 3);
    step();
    chk_port("R4", 2, 1, 1, 3);
    chk("R5", "drop bits", int'(drop_pulse), 3'b011);
    chk("R5", "shuffle valid", int'(pkt_out_vld[1:0]), 0);
    set_in(0, 1, 2, 3); set_in(1, 1, 3, 3);
    step();
    chk_port("R4", 2, 1, 2, 3);
    chk("R5", "drop bits", int'(drop_pulse), 3'b010);
  endtask

  task automatic t_drop_mixed();
    set_in(2, 1, 2, 3); set_in(0, 1, 6, 3); set_in(1, 1, 3'b011, 0);
    step();
    chk_port("R5", 2, 1, 2, 3);
    chk_port("R2", 1, 1, 3'b011, 1);
    chk_port("R5", 0, 0, 0, 0);
    chk("R5", "drop bits", int'(drop_pulse), 3'b001);
    step();
    chk("R5", "pulse one cycle", int'(drop_pulse), 0);
  endtask

  task automatic t_hop_win();
    set_in(0, 1, 3'b000, 1); set_in(1, 1, 3'b000, 2);
    step();
    chk_port("R6", 0, 1, 0, 3);
    chk_port("R7", 1, 1, 0, 0);
  endtask

  task automatic t_tie();
    set_in(0, 1, 3'b001, 0); set_in(1, 1, 3'b111, 0);
    step();
    chk_port("R6", 1, 1, 1, 1);
    chk_port("R7", 0, 1, 7, 0);
  endtask

  task automatic t_three_way();
    set_in(0, 1, 3'b000, 1); set_in(1, 1, 3'b001, 1); set_in(2, 1, 3'b100, 1);
    step();
    chk_port("R6", 0, 1, 0, 2);
    chk_port("R7", 1, 1, 1, 0);
    chk_port("R8", 2, 1, 4, 0);
    chk("R8", "drop", int'(drop_pulse), 0);
  endtask

  task automatic t_hz_taken();
    set_in(2, 1, 5, 3); set_in(0, 1, 3'b000, 0); set_in(1, 1, 3'b000, 2);
    step();
    chk_port("R3", 2, 1, 5, 3);
    chk_port("R6", 0, 1, 0, 3);
    chk_port("R7", 1, 1, 0, 0);
    chk("R8", "drop", int'(drop_pulse), 0);
  endtask

  task automatic t_invalid();
    pkt_in_vld = '0;
    pkt_in_dst = '1;
    pkt_in_hop = '1;
    step();
    chk("R9", "valid", int'(pkt_out_vld), 0);
    chk("R9", "drop", int'(drop_pulse), 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_route();
    t_arrive();
    t_hz_prio();
    t_drop_mixed();
    t_hop_win();
    t_tie();
    t_three_way();
    t_hz_taken();
    t_invalid();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule